// File: doc/BRIEF.md
# Register Move and Swap Eliminator

At the rename stage, some operations copy one architectural register to another (a move) or exchange two registers (a swap). This block decides, in the same cycle the operations are presented, whether each can be retired by aliasing instead of being executed. It has several rename lanes, taken in program order. When a lane's operation is eliminated, each destination gets an alias entry naming the register that now holds its value. The lane also reports which writes and reads carry a known zero.

Each register is described by four inputs: its bank, its rename root (the wider register it is renamed with), whether its class permits elimination, and whether it currently holds zero. Each bank has a per-cycle elimination budget and a zero-only switch. The alias table can be read through a lookup port. An ordinary (non-eliminated) write reported on the write port removes the alias of the register it writes.

Top module: `mv_elim`

## Requirements
- R1: A lane qualifies only when it is valid, its write count equals its read count, and that count is 1 (move) or 2 (swap); counts are 2-bit fields.
- R2: Source slot i is paired with destination slot (count-1-i), so a swap crosses its slots. Elimination is all-or-nothing: if any pair fails, no flag or alias is produced for the lane.
- R3: The bank used for the budget is the bank of destination slot 0. A lane is rejected when that bank's eliminations earlier in the cycle plus the lane's write count exceed the bank's limit. A limit of 0 means unlimited.
- R4: Elimination counts start from zero in every cycle. Lanes are counted in index order, so a lane sees only the eliminations of lower-numbered lanes in the same cycle.
- R5: Every pair's source and destination must both be in the lane's bank, and the rename root of the destination must have its elimination-permit bit set.
- R6: A destination whose rename root differs from itself (a partial register) is rejected unless the lane's clear-upper flag for that destination slot is set.
- R7: When the lane's bank is in zero-only mode, a pair is accepted only if its source is marked zero.
- R8: The alias target of a pair is the rename root of its source. If that root has a valid alias in the table as it stood at the start of the cycle, the target is that root's target instead. The target is written to both the destination and the destination's root on the next clock edge. Later lanes overwrite earlier ones.
- R9: For an eliminated pair whose source is marked zero, the read flag of the source slot and the write flag of the paired destination slot are raised.
- R10: A valid ordinary write invalidates the alias entries of the written register and of its root on the next edge. An alias set by an elimination in the same cycle takes precedence.
- R11: After reset every alias entry is invalid.
- R12: A lane that is not eliminated raises no write-zero or read-zero flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_bank_i | input | NUM_REGS x BANK_W | Bank of each register |
| reg_root_i | input | NUM_REGS x REG_W | Rename root of each register |
| reg_elim_ok_i | input | NUM_REGS | Class of register permits elimination |
| zero_map_i | input | NUM_REGS | Register currently holds zero |
| bank_limit_i | input | NUM_BANKS x LIMIT_W | Per-cycle elimination limit, 0 = unlimited |
| bank_zero_only_i | input | NUM_BANKS | Bank eliminates zero moves only |
| op_valid_i | input | NUM_LANES | Lane carries an operation |
| op_nwr_i | input | NUM_LANES x 2 | Write count |
| op_nrd_i | input | NUM_LANES x 2 | Read count |
| op_src_i | input | NUM_LANES x 2 x REG_W | Source registers by slot |
| op_dst_i | input | NUM_LANES x 2 x REG_W | Destination registers by slot |
| op_clr_i | input | NUM_LANES x 2 | Destination write clears upper portion |
| wr_valid_i | input | 1 | Ordinary write installed this cycle |
| wr_reg_i | input | REG_W | Register of the ordinary write |
| look_reg_i | input | REG_W | Alias lookup register |
| elim_o | output | NUM_LANES | Lane is eliminated |
| wzero_o | output | NUM_LANES x 2 | Write-zero flag per destination slot |
| rzero_o | output | NUM_LANES x 2 | Read-zero flag per source slot |
| look_valid_o | output | 1 | Looked-up register has an alias |
| look_target_o | output | REG_W | Alias target of looked-up register |

## Verification
The bench drives a chained move after a move. If the table were not followed one level, the second alias would point at the intermediate register instead of the original. It drives swaps whose slots must cross: pairing slots straight would check the wrong destination bank and class, and put zero flags on the wrong slot. It also checks that a swap with one bad pair leaves the table untouched.

Two lanes in one bank are run against a tight limit. A design that forgot earlier lanes, or kept counts from the previous cycle, would accept the second lane or reject a lane it should admit. Further cases cover partial destinations with and without the clear flag, zero-only banks with zero and non-zero sources, and an ordinary write colliding with an elimination.

// File: rtl/mv_elim_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the move/swap eliminator.
// Assumes an operation carries at most two writes and two reads.
package mv_elim_pkg;

    localparam int unsigned PAIR_SLOTS = 2;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_MOVE = 2'd1,
        OP_SWAP = 2'd2
    } op_kind_e;

    // Classify a lane: move or swap only when write and read counts agree.
    function automatic op_kind_e classify(input logic valid,
                                          input logic [1:0] nwr,
                                          input logic [1:0] nrd);
        if (!valid || nwr != nrd) return OP_NONE;
        if (nwr == 2'd1)          return OP_MOVE;
        if (nwr == 2'd2)          return OP_SWAP;
        return OP_NONE;
    endfunction

endpackage

// File: rtl/mv_elim_pair.sv
`timescale 1ns/1ps
// Checks one source/destination pair of a lane and computes its alias target.
// Assumes the alias table inputs are the registered state of this cycle.
// An unused pair reports pair_ok high so the lane's AND is unaffected.
module mv_elim_pair #(
    parameter int NUM_REGS = 16,
    parameter int REG_W    = 4,
    parameter int BANK_W   = 1
) (
    input  logic                               pair_used,
    input  logic [REG_W-1:0]                   src,
    input  logic [REG_W-1:0]                   dst,
    input  logic                               clr_upper,
    input  logic [BANK_W-1:0]                  lane_bank,
    input  logic                               zero_only,
    input  logic [NUM_REGS-1:0][BANK_W-1:0]    reg_bank,
    input  logic [NUM_REGS-1:0][REG_W-1:0]     reg_root,
    input  logic [NUM_REGS-1:0]                elim_ok,
    input  logic [NUM_REGS-1:0]                zero_map,
    input  logic [NUM_REGS-1:0]                alias_v,
    input  logic [NUM_REGS-1:0][REG_W-1:0]     alias_t,
    output logic                               pair_ok,
    output logic                               src_zero,
    output logic [REG_W-1:0]                   target,
    output logic [REG_W-1:0]                   dst_root
);

    logic [REG_W-1:0] src_root;
    logic             same_bank;
    logic             class_ok;
    logic             width_ok;
    logic             zero_ok;

    // Qualification of the pair against bank, class, width and zero-only rules.
    always_comb begin
        src_root  = reg_root[src];
        dst_root  = reg_root[dst];
        src_zero  = zero_map[src];
        same_bank = (reg_bank[src] == lane_bank) && (reg_bank[dst] == lane_bank);
        class_ok  = elim_ok[dst_root];
        width_ok  = (dst_root == dst) || clr_upper;
        zero_ok   = !zero_only || src_zero;
        pair_ok   = !pair_used || (same_bank && class_ok && width_ok && zero_ok);
    end

    // Alias target: source root, followed one level through the table.
    always_comb begin
        target = alias_v[src_root] ? alias_t[src_root] : src_root;
    end

endmodule

// File: rtl/mv_elim_lane.sv
`timescale 1ns/1ps
// One rename lane: qualifies a move or swap, applies the bank budget and
// produces flags and alias updates. Bank counts arrive from lower lanes and
// leave updated for higher lanes. Pair p reads source slot p and writes
// destination slot (count-1-p).
module mv_elim_lane
    import mv_elim_pkg::*;
#(
    parameter int NUM_REGS  = 16,
    parameter int NUM_BANKS = 2,
    parameter int REG_W     = 4,
    parameter int BANK_W    = 1,
    parameter int LIMIT_W   = 3,
    parameter int CNT_W     = 4
) (
    input  logic                                 op_valid,
    input  logic [1:0]                           op_nwr,
    input  logic [1:0]                           op_nrd,
    input  logic [1:0][REG_W-1:0]                op_src,
    input  logic [1:0][REG_W-1:0]                op_dst,
    input  logic [1:0]                           op_clr,
    input  logic [NUM_REGS-1:0][BANK_W-1:0]      reg_bank,
    input  logic [NUM_REGS-1:0][REG_W-1:0]       reg_root,
    input  logic [NUM_REGS-1:0]                  elim_ok,
    input  logic [NUM_REGS-1:0]                  zero_map,
    input  logic [NUM_BANKS-1:0][LIMIT_W-1:0]    bank_limit,
    input  logic [NUM_BANKS-1:0]                 bank_zero_only,
    input  logic [NUM_REGS-1:0]                  alias_v,
    input  logic [NUM_REGS-1:0][REG_W-1:0]       alias_t,
    input  logic [NUM_BANKS-1:0][CNT_W-1:0]      cnt_in,
    output logic [NUM_BANKS-1:0][CNT_W-1:0]      cnt_out,
    output logic                                 elim,
    output logic [1:0]                           wzero,
    output logic [1:0]                           rzero,
    output logic [1:0]                           upd_en,
    output logic [1:0][REG_W-1:0]                upd_dst,
    output logic [1:0][REG_W-1:0]                upd_root,
    output logic [1:0][REG_W-1:0]                upd_tgt
);

    op_kind_e          kind;
    logic              swap;
    logic [BANK_W-1:0] bank;
    logic [CNT_W-1:0]  sum;
    logic [CNT_W-1:0]  lim_ext;
    logic              over;
    logic [1:0]        used;
    logic [1:0]        pair_ok;
    logic [1:0]        src_zero;
    logic [1:0]        wsel;
    logic [1:0][REG_W-1:0] dsel;
    logic [1:0][REG_W-1:0] tgt;
    logic [1:0][REG_W-1:0] droot;

    // Operation class and the bank that owns the lane.
    always_comb begin
        kind = classify(op_valid, op_nwr, op_nrd);
        swap = (kind == OP_SWAP);
        bank = reg_bank[op_dst[0]];
    end

    genvar p;
    generate
        for (p = 0; p < PAIR_SLOTS; p++) begin : g_pair
            localparam logic SELF  = 1'(p);
            localparam logic OTHER = 1'(PAIR_SLOTS - 1 - p);

            // Pair activity and the destination slot it writes.
            assign used[p] = (kind != OP_NONE) && ((SELF == 1'b0) || swap);
            assign wsel[p] = swap ? OTHER : SELF;
            assign dsel[p] = op_dst[wsel[p]];

            mv_elim_pair #(
                .NUM_REGS (NUM_REGS),
                .REG_W    (REG_W),
                .BANK_W   (BANK_W)
            ) u_pair (
                .pair_used (used[p]),
                .src       (op_src[p]),
                .dst       (dsel[p]),
                .clr_upper (op_clr[wsel[p]]),
                .lane_bank (bank),
                .zero_only (bank_zero_only[bank]),
                .reg_bank  (reg_bank),
                .reg_root  (reg_root),
                .elim_ok   (elim_ok),
                .zero_map  (zero_map),
                .alias_v   (alias_v),
                .alias_t   (alias_t),
                .pair_ok   (pair_ok[p]),
                .src_zero  (src_zero[p]),
                .target    (tgt[p]),
                .dst_root  (droot[p])
            );
        end
    endgenerate

    // Per-cycle budget of the lane's bank; a zero limit disables it.
    always_comb begin
        sum     = cnt_in[bank] + CNT_W'(op_nwr);
        lim_ext = CNT_W'(bank_limit[bank]);
        over    = (lim_ext != '0) && (sum > lim_ext);
        elim    = (kind != OP_NONE) && !over && (&pair_ok);
    end

    // Hand the bank counts on to the next lane.
    always_comb begin
        cnt_out = cnt_in;
        if (elim) cnt_out[bank] = sum;
    end

    // Zero flags: read flag on the source slot, write flag on its partner slot.
    always_comb begin
        wzero = '0;
        rzero = '0;
        for (int i = 0; i < PAIR_SLOTS; i++) begin
            if (elim && used[i] && src_zero[i]) begin
                rzero[i]       = 1'b1;
                wzero[wsel[i]] = 1'b1;
            end
        end
    end

    // Alias updates offered to the table.
    always_comb begin
        upd_en   = used & {2{elim}};
        upd_dst  = dsel;
        upd_root = droot;
        upd_tgt  = tgt;
    end

endmodule

// File: rtl/mv_elim_alias.sv
`timescale 1ns/1ps
// Alias table: one valid bit and target per register. An ordinary write
// clears entries first, then lane updates are applied in lane and pair
// order, so eliminations win and later lanes win.
module mv_elim_alias #(
    parameter int NUM_REGS  = 16,
    parameter int NUM_LANES = 2,
    parameter int REG_W     = 4
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   wr_valid,
    input  logic [REG_W-1:0]                       wr_reg,
    input  logic [REG_W-1:0]                       wr_root,
    input  logic [NUM_LANES-1:0][1:0]              upd_en,
    input  logic [NUM_LANES-1:0][1:0][REG_W-1:0]   upd_dst,
    input  logic [NUM_LANES-1:0][1:0][REG_W-1:0]   upd_root,
    input  logic [NUM_LANES-1:0][1:0][REG_W-1:0]   upd_tgt,
    input  logic [REG_W-1:0]                       look_reg,
    output logic [NUM_REGS-1:0]                    alias_v,
    output logic [NUM_REGS-1:0][REG_W-1:0]         alias_t,
    output logic                                   look_valid,
    output logic [REG_W-1:0]                       look_target
);

    logic [NUM_REGS-1:0]            v_d;
    logic [NUM_REGS-1:0][REG_W-1:0] t_d;

    // Next table state: clear for ordinary writes, then set for eliminations.
    always_comb begin
        v_d = alias_v;
        t_d = alias_t;
        if (wr_valid) begin
            v_d[wr_reg]  = 1'b0;
            v_d[wr_root] = 1'b0;
        end
        for (int l = 0; l < NUM_LANES; l++) begin
            for (int q = 0; q < 2; q++) begin
                if (upd_en[l][q]) begin
                    v_d[upd_root[l][q]] = 1'b1;
                    t_d[upd_root[l][q]] = upd_tgt[l][q];
                    v_d[upd_dst[l][q]]  = 1'b1;
                    t_d[upd_dst[l][q]]  = upd_tgt[l][q];
                end
            end
        end
    end

    // Table registers with synchronous reset to all-invalid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alias_v <= '0;
            alias_t <= '0;
        end else begin
            alias_v <= v_d;
            alias_t <= t_d;
        end
    end

    // Lookup port reads the registered table.
    always_comb begin
        look_valid  = alias_v[look_reg];
        look_target = alias_t[look_reg];
    end

endmodule

// File: rtl/mv_elim.sv
`timescale 1ns/1ps
// Move/swap eliminator top. Decisions are combinational in the cycle the
// lanes are presented; alias state is registered. Lanes are in program order,
// and all of them read the table as it stood at the start of the cycle.
module mv_elim #(
    parameter int NUM_REGS  = 16,
    parameter int NUM_BANKS = 2,
    parameter int NUM_LANES = 2,
    parameter int LIMIT_W   = 3,
    localparam int REG_W    = $clog2(NUM_REGS),
    localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic [NUM_REGS-1:0][BANK_W-1:0]        reg_bank_i,
    input  logic [NUM_REGS-1:0][REG_W-1:0]         reg_root_i,
    input  logic [NUM_REGS-1:0]                    reg_elim_ok_i,
    input  logic [NUM_REGS-1:0]                    zero_map_i,
    input  logic [NUM_BANKS-1:0][LIMIT_W-1:0]      bank_limit_i,
    input  logic [NUM_BANKS-1:0]                   bank_zero_only_i,
    input  logic [NUM_LANES-1:0]                   op_valid_i,
    input  logic [NUM_LANES-1:0][1:0]              op_nwr_i,
    input  logic [NUM_LANES-1:0][1:0]              op_nrd_i,
    input  logic [NUM_LANES-1:0][1:0][REG_W-1:0]   op_src_i,
    input  logic [NUM_LANES-1:0][1:0][REG_W-1:0]   op_dst_i,
    input  logic [NUM_LANES-1:0][1:0]              op_clr_i,
    input  logic                                   wr_valid_i,
    input  logic [REG_W-1:0]                       wr_reg_i,
    input  logic [REG_W-1:0]                       look_reg_i,
    output logic [NUM_LANES-1:0]                   elim_o,
    output logic [NUM_LANES-1:0][1:0]              wzero_o,
    output logic [NUM_LANES-1:0][1:0]              rzero_o,
    output logic                                   look_valid_o,
    output logic [REG_W-1:0]                       look_target_o
);

    localparam int LANE_MAX = $clog2(2 * NUM_LANES + 1);
    localparam int CNT_W    = ((LANE_MAX > LIMIT_W) ? LANE_MAX : LIMIT_W) + 1;

    logic [NUM_REGS-1:0]                   alias_v;
    logic [NUM_REGS-1:0][REG_W-1:0]        alias_t;
    logic [NUM_LANES:0][NUM_BANKS-1:0][CNT_W-1:0] cnt_chain;
    logic [NUM_LANES-1:0][1:0]             upd_en;
    logic [NUM_LANES-1:0][1:0][REG_W-1:0]  upd_dst;
    logic [NUM_LANES-1:0][1:0][REG_W-1:0]  upd_root;
    logic [NUM_LANES-1:0][1:0][REG_W-1:0]  upd_tgt;

    // Counts start from zero each cycle at the first lane.
    assign cnt_chain[0] = '0;

    genvar k;
    generate
        for (k = 0; k < NUM_LANES; k++) begin : g_lane
            mv_elim_lane #(
                .NUM_REGS  (NUM_REGS),
                .NUM_BANKS (NUM_BANKS),
                .REG_W     (REG_W),
                .BANK_W    (BANK_W),
                .LIMIT_W   (LIMIT_W),
                .CNT_W     (CNT_W)
            ) u_lane (
                .op_valid       (op_valid_i[k]),
                .op_nwr         (op_nwr_i[k]),
                .op_nrd         (op_nrd_i[k]),
                .op_src         (op_src_i[k]),
                .op_dst         (op_dst_i[k]),
                .op_clr         (op_clr_i[k]),
                .reg_bank       (reg_bank_i),
                .reg_root       (reg_root_i),
                .elim_ok        (reg_elim_ok_i),
                .zero_map       (zero_map_i),
                .bank_limit     (bank_limit_i),
                .bank_zero_only (bank_zero_only_i),
                .alias_v        (alias_v),
                .alias_t        (alias_t),
                .cnt_in         (cnt_chain[k]),
                .cnt_out        (cnt_chain[k+1]),
                .elim           (elim_o[k]),
                .wzero          (wzero_o[k]),
                .rzero          (rzero_o[k]),
                .upd_en         (upd_en[k]),
                .upd_dst        (upd_dst[k]),
                .upd_root       (upd_root[k]),
                .upd_tgt        (upd_tgt[k])
            );
        end
    endgenerate

    mv_elim_alias #(
        .NUM_REGS  (NUM_REGS),
        .NUM_LANES (NUM_LANES),
        .REG_W     (REG_W)
    ) u_alias (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_valid    (wr_valid_i),
        .wr_reg      (wr_reg_i),
        .wr_root     (reg_root_i[wr_reg_i]),
        .upd_en      (upd_en),
        .upd_dst     (upd_dst),
        .upd_root    (upd_root),
        .upd_tgt     (upd_tgt),
        .look_reg    (look_reg_i),
        .alias_v     (alias_v),
        .alias_t     (alias_t),
        .look_valid  (look_valid_o),
        .look_target (look_target_o)
    );

endmodule

// File: rtl/mv_elim_chk.sv
`timescale 1ns/1ps
// Assertion checker bound to mv_elim; observes ports only.
module mv_elim_chk #(
    parameter int NUM_REGS  = 16,
    parameter int NUM_BANKS = 2,
    parameter int NUM_LANES = 2,
    parameter int LIMIT_W   = 3,
    parameter int REG_W     = 4,
    parameter int BANK_W    = 1
) (
    input logic                                   clk,
    input logic                                   rst_n,
    input logic [NUM_REGS-1:0][BANK_W-1:0]        reg_bank_i,
    input logic [NUM_REGS-1:0]                    zero_map_i,
    input logic [NUM_BANKS-1:0][LIMIT_W-1:0]      bank_limit_i,
    input logic [NUM_BANKS-1:0]                   bank_zero_only_i,
    input logic [NUM_LANES-1:0]                   op_valid_i,
    input logic [NUM_LANES-1:0][1:0]              op_nwr_i,
    input logic [NUM_LANES-1:0][1:0]              op_nrd_i,
    input logic [NUM_LANES-1:0][1:0][REG_W-1:0]   op_src_i,
    input logic [NUM_LANES-1:0][1:0][REG_W-1:0]   op_dst_i,
    input logic                                   wr_valid_i,
    input logic [REG_W-1:0]                       wr_reg_i,
    input logic [REG_W-1:0]                       look_reg_i,
    input logic [NUM_LANES-1:0]                   elim_o,
    input logic [NUM_LANES-1:0][1:0]              wzero_o,
    input logic [NUM_LANES-1:0][1:0]              rzero_o,
    input logic                                   look_valid_o
);

    genvar k;
    generate
        for (k = 0; k < NUM_LANES; k++) begin : g_chk
            a_r1_qualify: assert property (@(posedge clk) disable iff (!rst_n)
                elim_o[k] |-> (op_valid_i[k] && op_nwr_i[k] == op_nrd_i[k] &&
                               (op_nwr_i[k] == 2'd1 || op_nwr_i[k] == 2'd2)));

            a_r12_quiet_flags: assert property (@(posedge clk) disable iff (!rst_n)
                !elim_o[k] |-> (wzero_o[k] == 2'b00 && rzero_o[k] == 2'b00));

            a_r3_within_limit: assert property (@(posedge clk) disable iff (!rst_n)
                (elim_o[k] && bank_limit_i[reg_bank_i[op_dst_i[k][0]]] != '0) |->
                (int'(op_nwr_i[k]) <= int'(bank_limit_i[reg_bank_i[op_dst_i[k][0]]])));

            a_r7_zero_only: assert property (@(posedge clk) disable iff (!rst_n)
                (elim_o[k] && bank_zero_only_i[reg_bank_i[op_dst_i[k][0]]]) |->
                zero_map_i[op_src_i[k][0]]);

            a_r9_move_flags: assert property (@(posedge clk) disable iff (!rst_n)
                (elim_o[k] && op_nwr_i[k] == 2'd1) |->
                (rzero_o[k][0] == zero_map_i[op_src_i[k][0]] &&
                 wzero_o[k][0] == zero_map_i[op_src_i[k][0]]));
        end
    endgenerate

    a_r10_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_valid_i) && !$past(|elim_o) && look_reg_i == $past(wr_reg_i)) |->
        !look_valid_o);

endmodule

bind mv_elim mv_elim_chk #(
    .NUM_REGS  (NUM_REGS),
    .NUM_BANKS (NUM_BANKS),
    .NUM_LANES (NUM_LANES),
    .LIMIT_W   (LIMIT_W),
    .REG_W     (REG_W),
    .BANK_W    (BANK_W)
) u_chk (.*);

// File: tb/mv_elim_tb.sv
`timescale 1ns/1ps
// Bench for mv_elim: behavioural reference model compared on every cycle.
module mv_elim_tb;

    localparam int NR = 16;
    localparam int NB = 2;
    localparam int NL = 2;
    localparam int LW = 3;
    localparam int RW = 4;
    localparam int BW = 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    logic [NR-1:0][BW-1:0]       reg_bank;
    logic [NR-1:0][RW-1:0]       reg_root;
    logic [NR-1:0]               elim_ok;
    logic [NR-1:0]               zero_map;
    logic [NB-1:0][LW-1:0]       bank_limit;
    logic [NB-1:0]               zero_only;
    logic [NL-1:0]               op_valid;
    logic [NL-1:0][1:0]          op_nwr;
    logic [NL-1:0][1:0]          op_nrd;
    logic [NL-1:0][1:0][RW-1:0]  op_src;
    logic [NL-1:0][1:0][RW-1:0]  op_dst;
    logic [NL-1:0][1:0]          op_clr;
    logic                        wr_valid;
    logic [RW-1:0]               wr_reg;
    logic [RW-1:0]               look_reg;
    logic [NL-1:0]               elim;
    logic [NL-1:0][1:0]          wzero;
    logic [NL-1:0][1:0]          rzero;
    logic                        look_valid;
    logic [RW-1:0]               look_target;

    mv_elim #(.NUM_REGS(NR), .NUM_BANKS(NB), .NUM_LANES(NL), .LIMIT_W(LW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .reg_bank_i(reg_bank), .reg_root_i(reg_root), .reg_elim_ok_i(elim_ok),
        .zero_map_i(zero_map), .bank_limit_i(bank_limit), .bank_zero_only_i(zero_only),
        .op_valid_i(op_valid), .op_nwr_i(op_nwr), .op_nrd_i(op_nrd),
        .op_src_i(op_src), .op_dst_i(op_dst), .op_clr_i(op_clr),
        .wr_valid_i(wr_valid), .wr_reg_i(wr_reg), .look_reg_i(look_reg),
        .elim_o(elim), .wzero_o(wzero), .rzero_o(rzero),
        .look_valid_o(look_valid), .look_target_o(look_target)
    );

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 0;

    // Reference state
    int m_av[NR];
    int m_at[NR];
    int q_reg[$];
    int q_tgt[$];
    int e_elim[NL];
    int e_wz[NL][2];
    int e_rz[NL][2];

    task automatic chk(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Reference decision for all lanes (R1..R9).
    task automatic model_eval();
        int cnt[NB];
        for (int b = 0; b < NB; b++) cnt[b] = 0;
        q_reg.delete();
        q_tgt.delete();
        for (int k = 0; k < NL; k++) begin
            int n;
            int bk;
            bit ok;
            n  = int'(op_nwr[k]);
            bk = int'(reg_bank[op_dst[k][0]]);
            e_elim[k] = 0;
            for (int j = 0; j < 2; j++) begin e_wz[k][j] = 0; e_rz[k][j] = 0; end
            ok = op_valid[k] && (op_nwr[k] == op_nrd[k]) && (n == 1 || n == 2);
            if (ok && bank_limit[bk] != 0 && cnt[bk] + n > int'(bank_limit[bk])) ok = 0;
            if (ok) begin
                for (int i = 0; i < n; i++) begin
                    int s;
                    int w;
                    int d;
                    s = int'(op_src[k][i]);
                    w = n - 1 - i;
                    d = int'(op_dst[k][w]);
                    if (int'(reg_bank[s]) != bk || int'(reg_bank[d]) != bk) ok = 0;
                    if (!elim_ok[reg_root[d]]) ok = 0;
                    if (int'(reg_root[d]) != d && !op_clr[k][w]) ok = 0;
                    if (zero_only[bk] && !zero_map[s]) ok = 0;
                end
            end
            if (ok) begin
                e_elim[k] = 1;
                cnt[bk] += n;
                for (int i = 0; i < n; i++) begin
                    int s;
                    int w;
                    int d;
                    int r;
                    int t;
                    s = int'(op_src[k][i]);
                    w = n - 1 - i;
                    d = int'(op_dst[k][w]);
                    r = int'(reg_root[s]);
                    t = (m_av[r] != 0) ? m_at[r] : r;
                    q_reg.push_back(int'(reg_root[d])); q_tgt.push_back(t);
                    q_reg.push_back(d);                 q_tgt.push_back(t);
                    if (zero_map[s]) begin
                        e_rz[k][i] = 1;
                        e_wz[k][w] = 1;
                    end
                end
            end
        end
    endtask

    // Reference table update at the clock edge (R8, R10).
    task automatic model_commit();
        if (wr_valid) begin
            m_av[wr_reg] = 0;
            m_av[reg_root[wr_reg]] = 0;
        end
        for (int j = 0; j < q_reg.size(); j++) begin
            m_av[q_reg[j]] = 1;
            m_at[q_reg[j]] = q_tgt[q_reg[j] == q_reg[j] ? j : j];
        end
    endtask

    // One clock: compare outputs mid-low-phase, then advance the model.
    task automatic cycle(string req);
        #2;
        model_eval();
        for (int k = 0; k < NL; k++) begin
            chk(req, int'(elim[k]), e_elim[k]);
            for (int j = 0; j < 2; j++) begin
                chk("R9", int'(wzero[k][j]), e_wz[k][j]);
                chk("R9", int'(rzero[k][j]), e_rz[k][j]);
            end
        end
        chk("R8", int'(look_valid), m_av[look_reg]);
        if (m_av[look_reg] != 0) chk("R8", int'(look_target), m_at[look_reg]);
        @(posedge clk);
        model_commit();
        @(negedge clk);
    endtask

    task automatic set_idle();
        op_valid = '0; op_nwr = '0; op_nrd = '0;
        op_src = '0; op_dst = '0; op_clr = '0;
        wr_valid = 1'b0; wr_reg = '0;
    endtask

    task automatic mv(int k, int s, int d, bit c);
        op_valid[k] = 1'b1; op_nwr[k] = 2'd1; op_nrd[k] = 2'd1;
        op_src[k][0] = RW'(s); op_dst[k][0] = RW'(d); op_clr[k] = {1'b0, c};
    endtask

    task automatic sw(int k, int a, int b);
        op_valid[k] = 1'b1; op_nwr[k] = 2'd2; op_nrd[k] = 2'd2;
        op_src[k][0] = RW'(a); op_src[k][1] = RW'(b);
        op_dst[k][0] = RW'(a); op_dst[k][1] = RW'(b); op_clr[k] = 2'b00;
    endtask

    // Read every alias entry through the lookup port with the block idle.
    task automatic peek_all(string req);
        set_idle();
        for (int r = 0; r < NR; r++) begin
            look_reg = RW'(r);
            #1;
            chk(req, int'(look_valid), m_av[r]);
            if (m_av[r] != 0) chk(req, int'(look_target), m_at[r]);
        end
        @(negedge clk);
    endtask

    task automatic look(string req, int r, int v, int t);
        look_reg = RW'(r);
        #1;
        chk(req, int'(look_valid), v);
        if (v != 0) chk(req, int'(look_target), t);
    endtask

    // Watchdog: a hung run is one failed check.
    initial begin
        #(20 * 150000);
        if (!done) begin
            n_fails++;
            n_checks++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        for (int r = 0; r < NR; r++) begin
            m_av[r] = 0; m_at[r] = 0;
            reg_root[r] = (r >= 12) ? RW'(r - 4) : RW'(r);
            reg_bank[r] = (r >= 8) ? 1'b1 : 1'b0;
            elim_ok[r]  = (r != 7);
        end
        zero_map = '0;
        bank_limit[0] = LW'(2);
        bank_limit[1] = LW'(0);
        zero_only = '0;
        look_reg = '0;
        set_idle();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11: empty table after reset
        peek_all("R11");

        // R8: simple move then chained move resolves to the original
        mv(0, 1, 2, 0); cycle("R1");
        set_idle(); look("R8", 2, 1, 1);
        mv(0, 2, 3, 0); cycle("R8");
        set_idle(); look("R8", 3, 1, 1);

        // R2: swap crosses slots
        sw(0, 4, 5); cycle("R2");
        set_idle(); look("R2", 5, 1, 4); look("R2", 4, 1, 5);

        // R1: count mismatch and count of three
        mv(0, 1, 6, 0); op_nrd[0] = 2'd2; cycle("R1");
        chk("R1", int'(elim[0]), 0);
        set_idle();
        op_valid[0] = 1'b1; op_nwr[0] = 2'd3; op_nrd[0] = 2'd3; cycle("R1");
        chk("R1", int'(elim[0]), 0);

        // R3/R4: bank 0 limit 2; swap fills it, the next lane is refused
        set_idle(); sw(0, 0, 1); mv(1, 3, 6, 0); cycle("R3");
        chk("R3", int'(elim[1]), 0);
        set_idle(); mv(1, 3, 6, 0); cycle("R4");
        chk("R4", int'(elim[1]), 1);
        bank_limit[0] = LW'(1);
        set_idle(); mv(0, 1, 2, 0); mv(1, 3, 6, 0); cycle("R4");
        chk("R4", int'(elim[1]), 0);
        bank_limit[0] = LW'(2);

        // R3: unlimited bank 1 takes two swaps in one cycle
        set_idle(); sw(0, 8, 9); sw(1, 10, 11); cycle("R3");
        chk("R3", int'(elim), 3);

        // R5: cross-bank pair and forbidden class
        set_idle(); mv(0, 1, 9, 0); cycle("R5");
        chk("R5", int'(elim[0]), 0);
        set_idle(); mv(0, 1, 7, 0); cycle("R5");
        chk("R5", int'(elim[0]), 0);

        // R6: partial destination needs the clear flag
        set_idle(); mv(0, 9, 12, 0); cycle("R6");
        chk("R6", int'(elim[0]), 0);
        set_idle(); mv(0, 9, 12, 1); cycle("R6");
        chk("R6", int'(elim[0]), 1);

        // R7: zero-only bank
        zero_only[1] = 1'b1;
        set_idle(); mv(0, 10, 11, 0); cycle("R7");
        chk("R7", int'(elim[0]), 0);
        zero_map[10] = 1'b1;
        set_idle(); mv(0, 10, 11, 0); cycle("R7");
        chk("R7", int'(elim[0]), 1);
        zero_only[1] = 1'b0;
        zero_map = '0;

        // R9: zero source in a swap flags the crossed write slot
        zero_map[2] = 1'b1;
        set_idle(); sw(0, 2, 3); cycle("R9");
        chk("R9", int'(rzero[0]), 2'b01);
        chk("R9", int'(wzero[0]), 2'b10);
        zero_map = '0;

        // R2/R12: one bad pair blocks the whole swap and all flags
        zero_map[1] = 1'b1;
        set_idle(); sw(0, 1, 7); cycle("R2");
        chk("R2", int'(elim[0]), 0);
        chk("R12", int'(wzero[0]), 0);
        zero_map = '0;

        // R10: ordinary write clears; same-cycle elimination wins
        set_idle(); wr_valid = 1'b1; wr_reg = RW'(2); cycle("R10");
        set_idle(); look("R10", 2, 0, 0);
        set_idle(); mv(0, 1, 3, 0); wr_valid = 1'b1; wr_reg = RW'(3); cycle("R10");
        set_idle(); look("R10", 3, 1, m_at[3]);
        set_idle(); wr_valid = 1'b1; wr_reg = RW'(12); cycle("R10");
        set_idle(); look("R10", 8, 0, 0);
        peek_all("R8");

        // Mixed traffic against the model
        for (int c = 0; c < 400; c++) begin
            set_idle();
            zero_map = NR'($urandom);
            bank_limit[0] = LW'($urandom_range(0, 3));
            bank_limit[1] = LW'($urandom_range(0, 3));
            zero_only = NB'($urandom_range(0, 3) == 0 ? $urandom : 0);
            for (int k = 0; k < NL; k++) begin
                op_valid[k] = ($urandom_range(0, 4) != 0);
                op_nwr[k] = 2'($urandom_range(0, 3));
                op_nrd[k] = ($urandom_range(0, 3) != 0) ? op_nwr[k] : 2'($urandom);
                op_src[k][0] = RW'($urandom); op_src[k][1] = RW'($urandom);
                op_dst[k][0] = RW'($urandom); op_dst[k][1] = RW'($urandom);
                op_clr[k] = 2'($urandom);
            end
            wr_valid = ($urandom_range(0, 3) == 0);
            wr_reg = RW'($urandom);
            look_reg = RW'($urandom);
            cycle("R2");
        end
        peek_all("R8");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule